// File: doc/BRIEF.md
# Coupled Output-Compare PWM Generator

This block makes a pulse-width-modulated waveform from a free-running 16-bit timer count. It does not restart the count each period. The count advances once per prescaled tick, where the tick rate is the clock divided by a power of two chosen through a 3-bit select. Two compare channels watch the count:

- The **period channel** drives the output pin to a programmed level when it matches.
- The **on-time channel** inverts the pin when it matches.

Each on-time match moves both compare points forward by hardware. The period compare gains one period. The on-time compare is placed at the new period compare plus the on-time. The waveform therefore repeats with no further writes.

Software programs the block through a simple register write port, with no handshake. Each channel also keeps a sticky match flag, and a write of zero to a flag bit clears it. When the block is disabled, the pin is held low and both compare points stay frozen. Enabling it again reloads them from the current count. The on-time must be at least 1 and smaller than the period.

Top module: `pwm_oc_gen`

## Requirements
- R1: The timer count advances once every 2^S clocks, where S is the prescale select held in bits [2:0] of address 3. S resets to 2, which gives one tick every 4 clocks.
- R2: On a period-compare match, the pin takes the level held in bit 1 of the control register at address 2.
- R3: On an on-time-compare match, the pin inverts. With level 0 this gives a high time of P−T ticks, where P is the period (address 0) and T is the on-time (address 1).
- R4: Each on-time match advances the period compare by P and sets the on-time compare to the new period compare plus T. For 1 ≤ T < P the pin repeats every P ticks: high for T ticks when the level is 1, and low for T ticks when the level is 0.
- R6: A match on the period channel sets flag_period_o, and a match on the on-time channel sets flag_ontime_o. Each flag stays set until it is cleared.
- R7: A write to address 4 clears flag_period_o where data bit 0 is 0, and clears flag_ontime_o where data bit 1 is 0. A 1 in a bit leaves that flag unchanged. A match in the same cycle as a clear wins.
- R8: While bit 0 of the control register (enable) is 0, the pin is low from the second clock after the write onward. No match occurs, so no flag is set, and both compare points stay frozen. A new enable reloads the period compare with count+P and the on-time compare with count+P+T.
- R9: The compare arithmetic wraps modulo 2^16, so the waveform continues without a glitch across the count's rollover.
- R10: After reset the pin is low, both flags are clear, the block is disabled, and P and T are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address: 0 period, 1 on-time, 2 control, 3 prescale, 4 flag clear |
| wr_data_i | input | 16 | Write data |
| pwm_o | output | 1 | PWM output pin |
| flag_period_o | output | 1 | Sticky period-channel match flag |
| flag_ontime_o | output | 1 | Sticky on-time-channel match flag |

## Verification
The timing of each result is as follows:

- A register write takes effect on the clock edge that samples it.
- A pin change and a flag set appear on the same clock edge as the tick that carries the match.
- A disable reaches the pin one edge after the write.

Because every pin edge lands on a tick boundary, the bench measures the high and low durations in clocks between successive edges, sampling on falling clock edges. It compares each duration with the tick count times 2^S. A flag or pin level is read only after waiting at least two clocks past the write that should affect it. The sweep covers every legal on-time for three periods, three prescale values and both levels, and one long run crosses the count rollover.

// File: rtl/pwm_oc_pkg.sv
package pwm_oc_pkg;
  typedef enum logic [2:0] {
    REG_PERIOD   = 3'd0,
    REG_ONTIME   = 3'd1,
    REG_CTRL     = 3'd2,
    REG_PRESCALE = 3'd3,
    REG_FLAGCLR  = 3'd4
  } reg_addr_e;

  localparam int CH_PERIOD    = 0;
  localparam int CH_ONTIME    = 1;
  localparam int NUM_CH       = 2;
  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_LVL_BIT = 1;
endpackage

// File: rtl/pwm_oc_regs.sv
module pwm_oc_regs
  import pwm_oc_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int SEL_W   = 3,
  parameter int SEL_RST = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  output logic [CNT_W-1:0]  period_o,
  output logic [CNT_W-1:0]  ontime_o,
  output logic              en_o,
  output logic              level_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic              clr_wr_o,
  output logic [NUM_CH-1:0] clr_mask_o
);
  reg_addr_e addr;
  assign addr = reg_addr_e'(wr_addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_o <= '0;
      ontime_o <= '0;
      en_o     <= 1'b0;
      level_o  <= 1'b0;
      sel_o    <= SEL_W'(SEL_RST);
    end else if (wr_en_i) begin
      case (addr)
        REG_PERIOD:   period_o <= wr_data_i;
        REG_ONTIME:   ontime_o <= wr_data_i;
        REG_CTRL: begin
          en_o    <= wr_data_i[CTRL_EN_BIT];
          level_o <= wr_data_i[CTRL_LVL_BIT];
        end
        REG_PRESCALE: sel_o <= wr_data_i[SEL_W-1:0];
        default: ;
      endcase
    end
  end

  assign clr_wr_o   = wr_en_i && (addr == REG_FLAGCLR);
  assign clr_mask_o = wr_data_i[NUM_CH-1:0];
endmodule

// File: rtl/pwm_oc_timebase.sv
module pwm_oc_timebase #(
  parameter int CNT_W = 16,
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o,
  output logic [CNT_W-1:0] count_o
);
  localparam int PRE_W = (1 << SEL_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  always_comb begin
    mask = ~({PRE_W{1'b1}} << sel_i);
  end

  assign tick_o = ((pre_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q   <= '0;
      count_o <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
      if (tick_o) count_o <= count_o + 1'b1;
    end
  end

  // R1
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_o |=> $stable(count_o));
  // R1
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> count_o == CNT_W'($past(count_o) + 1'b1));
endmodule

// File: rtl/pwm_oc_compare.sv
module pwm_oc_compare #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] ontime_i,
  output logic             arm_o,
  output logic             per_match_o,
  output logic             on_match_o
);
  logic             en_prev_q;
  logic [CNT_W-1:0] cmp_per_q, cmp_on_q;
  logic [CNT_W-1:0] nxt_per, nxt_on;
  logic             live, load;

  assign arm_o       = en_i && !en_prev_q;
  assign live        = en_i && !arm_o && tick_i;
  assign per_match_o = live && (count_i == cmp_per_q);
  assign on_match_o  = live && (count_i == cmp_on_q);
  assign load        = arm_o || on_match_o;

  always_comb begin
    nxt_per = arm_o ? CNT_W'(count_i + period_i) : CNT_W'(cmp_per_q + period_i);
    nxt_on  = CNT_W'(nxt_per + ontime_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_prev_q <= 1'b0;
      cmp_per_q <= '0;
      cmp_on_q  <= '0;
    end else begin
      en_prev_q <= en_i;
      if (load) begin
        cmp_per_q <= nxt_per;
        cmp_on_q  <= nxt_on;
      end
    end
  end

  // R4
  adv_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> CNT_W'(cmp_on_q - cmp_per_q) == $past(ontime_i));
  // R8
  freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cmp_per_q) && $stable(cmp_on_q));
  // R8
  no_match_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !per_match_o && !on_match_o);
endmodule

// File: rtl/pwm_oc_flags.sv
module pwm_oc_flags #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_wr_i,
  input  logic [N-1:0] clr_mask_i,
  output logic [N-1:0] flag_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          flag_o[g] <= 1'b0;
      else if (set_i[g])                    flag_o[g] <= 1'b1;
      else if (clr_wr_i && !clr_mask_i[g])  flag_o[g] <= 1'b0;
    end

    // R6
    flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> flag_o[g]);
    // R7
    flag_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_wr_i && !clr_mask_i[g] && !set_i[g] |=> !flag_o[g]);
    // R7
    flag_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flag_o[g] && !(clr_wr_i && !clr_mask_i[g]) |=> flag_o[g]);
  end
endmodule

// File: rtl/pwm_oc_gen.sv
module pwm_oc_gen
  import pwm_oc_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int SEL_W   = 3,
  parameter int SEL_RST = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic             pwm_o,
  output logic             flag_period_o,
  output logic             flag_ontime_o
);
  logic [CNT_W-1:0]  period, ontime, count;
  logic              en, level, tick, arm, per_match, on_match, clr_wr;
  logic [SEL_W-1:0]  sel;
  logic [NUM_CH-1:0] clr_mask, set_vec, flags;
  logic              pin_q, pin_nxt;

  pwm_oc_regs #(.CNT_W(CNT_W), .SEL_W(SEL_W), .SEL_RST(SEL_RST)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .period_o(period), .ontime_o(ontime), .en_o(en), .level_o(level),
    .sel_o(sel), .clr_wr_o(clr_wr), .clr_mask_o(clr_mask)
  );

  pwm_oc_timebase #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_tb (
    .clk_i, .rst_ni, .sel_i(sel), .tick_o(tick), .count_o(count)
  );

  pwm_oc_compare #(.CNT_W(CNT_W)) u_cmp (
    .clk_i, .rst_ni, .en_i(en), .tick_i(tick), .count_i(count),
    .period_i(period), .ontime_i(ontime), .arm_o(arm),
    .per_match_o(per_match), .on_match_o(on_match)
  );

  always_comb begin
    set_vec            = '0;
    set_vec[CH_PERIOD] = per_match;
    set_vec[CH_ONTIME] = on_match;
  end

  pwm_oc_flags #(.N(NUM_CH)) u_flags (
    .clk_i, .rst_ni, .set_i(set_vec), .clr_wr_i(clr_wr),
    .clr_mask_i(clr_mask), .flag_o(flags)
  );

  // force first, then toggle: a coincident pair yields the inverted level
  always_comb begin
    pin_nxt = pin_q;
    if (per_match) pin_nxt = level;
    if (on_match)  pin_nxt = ~pin_nxt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          pin_q <= 1'b0;
    else if (!en || arm)  pin_q <= 1'b0;
    else                  pin_q <= pin_nxt;
  end

  assign pwm_o         = pin_q;
  assign flag_period_o = flags[CH_PERIOD];
  assign flag_ontime_o = flags[CH_ONTIME];

  // R8
  pin_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> !pwm_o);
  // R2
  force_lvl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_match && !on_match |=> pwm_o == $past(level));
  // R3
  toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    on_match && !per_match |=> pwm_o != $past(pwm_o));
  // R1
  match_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_match || on_match) |-> tick);
endmodule

// File: tb/pwm_oc_gen_tb.sv
`timescale 1ns/1ps
module pwm_oc_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        pwm, f_per, f_on;

  int n_chk = 0;
  int n_fail = 0;
  localparam int TMO = 4000;

  always #2 clk = ~clk;

  pwm_oc_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .pwm_o(pwm), .flag_period_o(f_per),
    .flag_ontime_o(f_on)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic measure(output int hi, output int lo);
    int t = 0;
    hi = 0; lo = 0;
    while (pwm !== 1'b1 && t < TMO) begin @(negedge clk); t++; end
    while (pwm === 1'b1 && hi < TMO) begin hi++; @(negedge clk); end
    while (pwm === 1'b0 && lo < TMO) begin lo++; @(negedge clk); end
  endtask

  task automatic run_case(input int s, input int l, input int p, input int t,
                          output int hi, output int lo);
    wr(3'd2, 16'h0000);
    wr(3'd0, 16'(p));
    wr(3'd1, 16'(t));
    wr(3'd3, 16'(s));
    wr(3'd2, 16'(l * 2 + 1));
    measure(hi, lo);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R4 actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int hi, lo, div, eh, el, bad;
    int plist[3];
    plist[0] = 2; plist[1] = 5; plist[2] = 9;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(pwm == 1'b0, "R10 pin", pwm, 0);
    chk(f_per == 1'b0 && f_on == 1'b0, "R10 flags", {f_on, f_per}, 0);

    // R1 default prescale divide-by-4, level 1
    wr(3'd0, 16'd5);
    wr(3'd1, 16'd2);
    wr(3'd2, 16'h0003);
    measure(hi, lo);
    chk(hi == 8, "R1 high", hi, 8);
    chk(lo == 12, "R1 low", lo, 12);
    // R6 both flags set after matches
    chk(f_per == 1'b1, "R6 period flag", f_per, 1);
    chk(f_on == 1'b1, "R6 ontime flag", f_on, 1);

    // R8 disable: pin low
    wr(3'd2, 16'h0000);
    @(negedge clk); @(negedge clk);
    chk(pwm == 1'b0, "R8 pin off", pwm, 0);
    // R7 partial clear: bit0=0 clears period flag, bit1=1 keeps on-time flag
    wr(3'd4, 16'h0002);
    @(negedge clk);
    chk(f_per == 1'b0, "R7 period cleared", f_per, 0);
    chk(f_on == 1'b1, "R7 ontime kept", f_on, 1);
    wr(3'd4, 16'h0000);
    @(negedge clk);
    chk(f_on == 1'b0, "R7 ontime cleared", f_on, 0);
    // R8 frozen while disabled: no pin activity, no flags
    bad = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (pwm || f_per || f_on) bad++;
    end
    chk(bad == 0, "R8 idle", bad, 0);

    // sweep prescale, level, period, on-time: R2 R3 R4
    for (int s = 0; s < 3; s++)
      for (int l = 0; l < 2; l++)
        for (int pi = 0; pi < 3; pi++)
          for (int t = 1; t < plist[pi]; t++) begin
            div = 1 << s;
            run_case(s, l, plist[pi], t, hi, lo);
            eh = (l == 1) ? t * div : (plist[pi] - t) * div;
            el = plist[pi] * div - eh;
            chk(hi == eh, (l == 1) ? "R2 high time" : "R3 high time", hi, eh);
            chk(lo == el, "R4 low time", lo, el);
          end

    // R9 long run across count rollover, divide-by-1
    run_case(0, 1, 7, 3, hi, lo);
    bad = 0;
    for (int k = 0; k < 10000; k++) begin
      measure(hi, lo);
      if (hi != 3 || lo != 4) bad++;
    end
    chk(bad == 0, "R9 wrap", bad, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule